// File: doc/BRIEF.md
# Instruction-cache miss tracker with flush-safe refill

This block holds the outstanding line misses of an instruction cache. It has two pools of entries: one for demand fetch misses and one for prefetch misses. A miss request is checked against every live entry. If no entry matches, the request takes a free entry in its own pool. Entries that have not yet been sent go out one at a time on a request channel to the next-level cache. Each request is tagged with a source identifier that names the entry.

A grant comes back with a full 64-byte line and two status bits: corrupt and denied. The grant is matched to its entry through the source identifier. One cycle later the block replies to the pipelines with the line address, the data and the status bits. In the same cycle it raises the write enables of the tag and data arrays and presents freshly generated parity bits.

A redirect flush or a fence can arrive at any time. An entry that has not gone out on the bus is removed at once. An entry that is already on the bus is kept but marked to be dropped. When its grant arrives, the entry is freed without a reply and without a write. A grant that meets a flush in the same cycle is still replied to, but nothing is written to the arrays.

Top module: `icmiss_unit`

## Requirements
- R1: After reset, both request-ready outputs are high. The bus request, the reply and both array write enables are low.
- R2: A new miss takes the lowest-numbered free entry of its pool. Fetch entry i uses source identifier i (0 to 3). Prefetch entry j uses source identifier 4+j (4 to 13). The bus request carries the entry's line address and source identifier. Entries are sent one per accepted handshake.
- R3: When entries of both pools are waiting, the bus request always offers a fetch entry first.
- R4: A miss whose line address matches a live entry of either pool is merged and gets no new entry. This includes a fetch miss accepted in the same cycle. Only one bus request results.
- R5: One cycle after a grant for a live, sent entry, the reply is valid and carries the entry's line address, the granted data and the corrupt and denied bits. Both array write enables are high in that cycle, and the entry is freed.
- R6: Each written parity bit k is the XOR of data bits 64k to 64k+63. The metadata parity bit is the XOR of the line address. All of these are inverted when the poison input is high in the grant cycle.
- R7: On a flush or fence, an entry that has not been sent is removed at once. It is never requested on the bus, and a later grant naming its identifier produces no reply.
- R8: On a flush or fence, a sent entry is held as pending-drop and no longer matches new misses. Its grant produces no reply and no write, and frees the entry for reuse.
- R9: A grant for a live entry that arrives in the same cycle as a flush or fence produces the reply one cycle later, with both write enables low.
- R10: While flush or fence is high, both request-ready outputs are low and no bus request is offered.
- R11: With all fetch entries busy, the fetch ready output is low for a non-matching address and high for a matching one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Redirect flush |
| fence | input | 1 | Instruction fence flush |
| fetch_req_valid | input | 1 | Fetch miss request |
| fetch_req_addr | input | 26 | Fetch miss line address |
| fetch_req_ready | output | 1 | Fetch miss can be taken |
| pf_req_valid | input | 1 | Prefetch miss request |
| pf_req_addr | input | 26 | Prefetch miss line address |
| pf_req_ready | output | 1 | Prefetch miss can be taken |
| bus_req_valid | output | 1 | Line request to next level |
| bus_req_ready | input | 1 | Next level takes the request |
| bus_req_addr | output | 26 | Requested line address |
| bus_req_src | output | 4 | Source identifier of the request |
| gnt_valid | input | 1 | Grant beat with a full line |
| gnt_src | input | 4 | Source identifier of the grant |
| gnt_data | input | 512 | Granted line data |
| gnt_corrupt | input | 1 | Grant data is corrupt |
| gnt_denied | input | 1 | Grant access was denied |
| poison | input | 1 | Invert the parity written at refill |
| resp_valid | output | 1 | Reply to the pipelines |
| resp_addr | output | 26 | Reply line address |
| resp_data | output | 512 | Reply line data |
| resp_corrupt | output | 1 | Reply corrupt status |
| resp_denied | output | 1 | Reply denied status |
| meta_we | output | 1 | Tag array write enable |
| data_we | output | 1 | Data array write enable |
| meta_parity | output | 1 | Parity bit for the tag array |
| data_parity | output | 8 | Parity bits for the data array, one per 64-bit chunk |

## Verification
The request-ready outputs and the bus request are combinational in the current entry state and inputs. The bench therefore sets its inputs just after a falling edge and checks these outputs one nanosecond later, before the next rising edge. An entry change caused by an allocation, a send handshake or a flush shows up on the bus request only from the following cycle. The reply, the write enables and the parity bits are registered once. Every grant is therefore driven for exactly one cycle, and these outputs are sampled at the next falling edge, which is one rising edge after the grant.

// File: rtl/icmiss_pkg.sv
`timescale 1ns/1ps
package icmiss_pkg;
    localparam int LINE_BITS  = 512;
    localparam int CHUNK_BITS = 64;
    localparam int NCHUNK     = LINE_BITS / CHUNK_BITS;
    localparam int LADDR_W    = 26;

    typedef logic [LADDR_W-1:0]   laddr_t;
    typedef logic [LINE_BITS-1:0] line_t;
    typedef logic [NCHUNK-1:0]    cpar_t;

    // One miss status entry
    typedef struct packed {
        logic   valid;
        logic   sent;      // request already on the bus
        logic   dropped;   // flushed while in flight
        laddr_t addr;
    } mshr_t;

    // Refill beat handed to the reply stage
    typedef struct packed {
        laddr_t addr;
        line_t  data;
        logic   corrupt;
        logic   denied;
        logic   poison;
    } refill_t;

    function automatic cpar_t chunk_parity(input line_t d, input logic inv);
        cpar_t p;
        for (int k = 0; k < NCHUNK; k++) begin
            p[k] = (^d[k*CHUNK_BITS +: CHUNK_BITS]) ^ inv;
        end
        return p;
    endfunction
endpackage

// File: rtl/icmiss_pool.sv
`timescale 1ns/1ps
module icmiss_pool
    import icmiss_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          alloc_en,
    input  laddr_t        alloc_addr,
    output logic          has_free,
    input  laddr_t        probe_a,
    input  laddr_t        probe_b,
    output logic          hit_a,
    output logic          hit_b,
    output logic          iss_valid,
    output logic [IW-1:0] iss_idx,
    output laddr_t        iss_addr,
    input  logic          iss_ack,
    input  logic          gnt_en,
    input  logic [IW-1:0] gnt_idx,
    output logic          gnt_live,
    output laddr_t        gnt_addr
);
    mshr_t         ent [N];
    logic [IW-1:0] free_idx;

    always_comb begin
        has_free  = 1'b0;
        free_idx  = '0;
        iss_valid = 1'b0;
        iss_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent[i].valid) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
            if (ent[i].valid && !ent[i].sent && !ent[i].dropped) begin
                iss_valid = 1'b1;
                iss_idx   = IW'(i);
            end
        end
    end

    always_comb begin
        hit_a    = 1'b0;
        hit_b    = 1'b0;
        gnt_live = 1'b0;
        gnt_addr = '0;
        iss_addr = '0;
        for (int i = 0; i < N; i++) begin
            // an entry retiring this cycle or awaiting drop cannot absorb a miss
            if (ent[i].valid && !ent[i].dropped && !(gnt_en && gnt_idx == IW'(i))) begin
                if (ent[i].addr == probe_a) hit_a = 1'b1;
                if (ent[i].addr == probe_b) hit_b = 1'b1;
            end
            if (gnt_idx == IW'(i)) begin
                gnt_live = gnt_en && ent[i].valid && ent[i].sent && !ent[i].dropped;
                gnt_addr = ent[i].addr;
            end
            if (iss_idx == IW'(i)) iss_addr = ent[i].addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (gnt_en && gnt_idx == IW'(i) && ent[i].valid && ent[i].sent) begin
                    ent[i].valid   <= 1'b0;
                    ent[i].dropped <= 1'b0;
                end else if (flush && ent[i].valid) begin
                    if (ent[i].sent) ent[i].dropped <= 1'b1;
                    else             ent[i].valid   <= 1'b0;
                end else begin
                    if (alloc_en && free_idx == IW'(i))
                        ent[i] <= '{valid: 1'b1, sent: 1'b0, dropped: 1'b0, addr: alloc_addr};
                    if (iss_ack && iss_valid && iss_idx == IW'(i))
                        ent[i].sent <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/icmiss_refill.sv
`timescale 1ns/1ps
module icmiss_refill
    import icmiss_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  logic    write,
    input  refill_t beat,
    output logic    resp_valid,
    output laddr_t  resp_addr,
    output line_t   resp_data,
    output logic    resp_corrupt,
    output logic    resp_denied,
    output logic    meta_we,
    output logic    data_we,
    output logic    meta_parity,
    output cpar_t   data_parity
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            meta_we    <= 1'b0;
            data_we    <= 1'b0;
        end else begin
            resp_valid <= fire;
            meta_we    <= write;
            data_we    <= write;
        end
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            resp_addr    <= beat.addr;
            resp_data    <= beat.data;
            resp_corrupt <= beat.corrupt;
            resp_denied  <= beat.denied;
            meta_parity  <= (^beat.addr) ^ beat.poison;
            data_parity  <= chunk_parity(beat.data, beat.poison);
        end
    end
endmodule

// File: rtl/icmiss_unit.sv
`timescale 1ns/1ps
module icmiss_unit
    import icmiss_pkg::*;
#(
    parameter int NFETCH = 4,
    parameter int NPREF  = 10,
    localparam int NTOT  = NFETCH + NPREF,
    localparam int SRC_W = $clog2(NTOT + 1),
    localparam int FIW   = (NFETCH > 1) ? $clog2(NFETCH) : 1,
    localparam int PIW   = (NPREF > 1) ? $clog2(NPREF) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      fence,
    input  logic                      fetch_req_valid,
    input  logic [LADDR_W-1:0]        fetch_req_addr,
    output logic                      fetch_req_ready,
    input  logic                      pf_req_valid,
    input  logic [LADDR_W-1:0]        pf_req_addr,
    output logic                      pf_req_ready,
    output logic                      bus_req_valid,
    input  logic                      bus_req_ready,
    output logic [LADDR_W-1:0]        bus_req_addr,
    output logic [SRC_W-1:0]          bus_req_src,
    input  logic                      gnt_valid,
    input  logic [SRC_W-1:0]          gnt_src,
    input  logic [LINE_BITS-1:0]      gnt_data,
    input  logic                      gnt_corrupt,
    input  logic                      gnt_denied,
    input  logic                      poison,
    output logic                      resp_valid,
    output logic [LADDR_W-1:0]        resp_addr,
    output logic [LINE_BITS-1:0]      resp_data,
    output logic                      resp_corrupt,
    output logic                      resp_denied,
    output logic                      meta_we,
    output logic                      data_we,
    output logic                      meta_parity,
    output logic [NCHUNK-1:0]         data_parity
);
    logic flush_any;
    assign flush_any = flush | fence;

    // pool status
    logic           f_free, p_free, f_hit_a, f_hit_b, p_hit_a, p_hit_b;
    logic           f_iss_v, p_iss_v, f_ack, p_ack;
    logic [FIW-1:0] f_iss_idx, f_gnt_idx;
    logic [PIW-1:0] p_iss_idx, p_gnt_idx;
    laddr_t         f_iss_addr, p_iss_addr, f_gnt_addr, p_gnt_addr;
    logic           f_gnt_en, p_gnt_en, f_gnt_live, p_gnt_live;
    logic           f_alloc, p_alloc, f_merge, p_merge;
    logic [SRC_W-1:0] p_off;

    // request acceptance and merging
    assign f_merge         = f_hit_a | p_hit_a;
    assign fetch_req_ready = !flush_any && (f_merge || f_free);
    assign f_alloc         = fetch_req_valid && fetch_req_ready && !f_merge;
    assign p_merge         = f_hit_b | p_hit_b | (f_alloc && fetch_req_addr == pf_req_addr);
    assign pf_req_ready    = !flush_any && (p_merge || p_free);
    assign p_alloc         = pf_req_valid && pf_req_ready && !p_merge;

    // bus request: fetch pool first
    assign bus_req_valid = !flush_any && (f_iss_v || p_iss_v);
    assign bus_req_addr  = f_iss_v ? f_iss_addr : p_iss_addr;
    assign bus_req_src   = f_iss_v ? SRC_W'(f_iss_idx) : SRC_W'(p_iss_idx) + SRC_W'(NFETCH);
    assign f_ack         = bus_req_valid && bus_req_ready && f_iss_v;
    assign p_ack         = bus_req_valid && bus_req_ready && !f_iss_v;

    // grant routing by source identifier
    assign p_off     = gnt_src - SRC_W'(NFETCH);
    assign f_gnt_en  = gnt_valid && (gnt_src < SRC_W'(NFETCH));
    assign p_gnt_en  = gnt_valid && (gnt_src >= SRC_W'(NFETCH)) && (gnt_src < SRC_W'(NTOT));
    assign f_gnt_idx = gnt_src[FIW-1:0];
    assign p_gnt_idx = p_off[PIW-1:0];

    icmiss_pool #(.N(NFETCH)) u_fpool (
        .clk(clk), .rst(rst), .flush(flush_any),
        .alloc_en(f_alloc), .alloc_addr(fetch_req_addr), .has_free(f_free),
        .probe_a(fetch_req_addr), .probe_b(pf_req_addr), .hit_a(f_hit_a), .hit_b(f_hit_b),
        .iss_valid(f_iss_v), .iss_idx(f_iss_idx), .iss_addr(f_iss_addr), .iss_ack(f_ack),
        .gnt_en(f_gnt_en), .gnt_idx(f_gnt_idx), .gnt_live(f_gnt_live), .gnt_addr(f_gnt_addr)
    );

    icmiss_pool #(.N(NPREF)) u_ppool (
        .clk(clk), .rst(rst), .flush(flush_any),
        .alloc_en(p_alloc), .alloc_addr(pf_req_addr), .has_free(p_free),
        .probe_a(fetch_req_addr), .probe_b(pf_req_addr), .hit_a(p_hit_a), .hit_b(p_hit_b),
        .iss_valid(p_iss_v), .iss_idx(p_iss_idx), .iss_addr(p_iss_addr), .iss_ack(p_ack),
        .gnt_en(p_gnt_en), .gnt_idx(p_gnt_idx), .gnt_live(p_gnt_live), .gnt_addr(p_gnt_addr)
    );

    refill_t beat;
    logic    fire;
    assign fire = f_gnt_live | p_gnt_live;
    assign beat = '{addr:    f_gnt_live ? f_gnt_addr : p_gnt_addr,
                    data:    gnt_data,
                    corrupt: gnt_corrupt,
                    denied:  gnt_denied,
                    poison:  poison};

    icmiss_refill u_refill (
        .clk(clk), .rst(rst), .fire(fire), .write(fire && !flush_any), .beat(beat),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_data(resp_data),
        .resp_corrupt(resp_corrupt), .resp_denied(resp_denied),
        .meta_we(meta_we), .data_we(data_we),
        .meta_parity(meta_parity), .data_parity(data_parity)
    );
endmodule

// File: rtl/icmiss_unit_chk.sv
`timescale 1ns/1ps
module icmiss_unit_chk
    import icmiss_pkg::*;
#(
    parameter int NFETCH = 4,
    parameter int NPREF  = 10,
    localparam int SRC_W = $clog2(NFETCH + NPREF + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               fence,
    input logic               fetch_req_ready,
    input logic               pf_req_ready,
    input logic               bus_req_valid,
    input logic [SRC_W-1:0]   bus_req_src,
    input logic               gnt_valid,
    input logic               poison,
    input logic               resp_valid,
    input logic [LADDR_W-1:0] resp_addr,
    input logic               meta_we,
    input logic               meta_parity
);
    assert_quiet_in_flush_R10: assert property (@(posedge clk) disable iff (rst)
        (flush || fence) |-> (!bus_req_valid && !fetch_req_ready && !pf_req_ready));

    assert_no_write_on_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (flush || fence) |=> !meta_we);

    assert_write_has_reply_R5: assert property (@(posedge clk) disable iff (rst)
        meta_we |-> resp_valid);

    assert_reply_follows_grant_R5: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(gnt_valid));

    assert_meta_parity_R6: assert property (@(posedge clk) disable iff (rst)
        meta_we |-> (meta_parity == ((^resp_addr) ^ $past(poison))));

    assert_src_range_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> (bus_req_src < SRC_W'(NFETCH + NPREF)));
endmodule

bind icmiss_unit icmiss_unit_chk #(.NFETCH(NFETCH), .NPREF(NPREF)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .fence(fence),
    .fetch_req_ready(fetch_req_ready), .pf_req_ready(pf_req_ready),
    .bus_req_valid(bus_req_valid), .bus_req_src(bus_req_src),
    .gnt_valid(gnt_valid), .poison(poison),
    .resp_valid(resp_valid), .resp_addr(resp_addr),
    .meta_we(meta_we), .meta_parity(meta_parity)
);

// File: tb/icmiss_unit_tb.sv
`timescale 1ns/1ps
module icmiss_unit_tb;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 0, fence = 0;
    logic          fetch_req_valid = 0, pf_req_valid = 0;
    logic [25:0]   fetch_req_addr = '0, pf_req_addr = '0;
    logic          fetch_req_ready, pf_req_ready;
    logic          bus_req_valid, bus_req_ready = 0;
    logic [25:0]   bus_req_addr;
    logic [3:0]    bus_req_src;
    logic          gnt_valid = 0, gnt_corrupt = 0, gnt_denied = 0, poison = 0;
    logic [3:0]    gnt_src = '0;
    logic [511:0]  gnt_data = '0;
    logic          resp_valid, resp_corrupt, resp_denied, meta_we, data_we, meta_parity;
    logic [25:0]   resp_addr;
    logic [511:0]  resp_data;
    logic [7:0]    data_parity;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    icmiss_unit u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_line(input logic [63:0] seed);
        logic [511:0] d;
        for (int k = 0; k < 8; k++) d[k*64 +: 64] = seed * 64'h9E37_79B9_7F4A_7C15 + 64'(k * 3 + 1);
        return d;
    endfunction

    // drive one cycle of miss requests; ready is checked before the edge
    task automatic req(input bit fv, input logic [25:0] fa, input bit pv, input logic [25:0] pa,
                       input bit exp_fr, input bit exp_pr, input string tag);
        @(negedge clk);
        fetch_req_valid = fv; fetch_req_addr = fa;
        pf_req_valid = pv; pf_req_addr = pa;
        #1;
        if (fv) chk(fetch_req_ready == exp_fr, tag, 64'(fetch_req_ready), 64'(exp_fr));
        if (pv) chk(pf_req_ready == exp_pr, tag, 64'(pf_req_ready), 64'(exp_pr));
        @(negedge clk);
        fetch_req_valid = 0; pf_req_valid = 0;
    endtask

    task automatic issue(input int src, input logic [25:0] addr, input string tag);
        @(negedge clk);
        #1;
        chk(bus_req_valid == 1'b1, tag, 64'(bus_req_valid), 64'd1);
        chk(bus_req_src == 4'(src), tag, 64'(bus_req_src), 64'(src));
        chk(bus_req_addr == addr, tag, 64'(bus_req_addr), 64'(addr));
        bus_req_ready = 1;
        @(negedge clk);
        bus_req_ready = 0;
    endtask

    task automatic bus_idle(input string tag);
        @(negedge clk);
        #1;
        chk(bus_req_valid == 1'b0, tag, 64'(bus_req_valid), 64'd0);
    endtask

    task automatic grant(input int src, input logic [63:0] seed, input bit corr, input bit den,
                         input bit pois, input bit with_flush, input bit exp_resp, input bit exp_we,
                         input logic [25:0] exp_addr, input string tag);
        logic [511:0] d;
        logic [7:0]   dp;
        d = mk_line(seed);
        for (int k = 0; k < 8; k++) dp[k] = (^d[k*64 +: 64]) ^ pois;
        @(negedge clk);
        gnt_valid = 1; gnt_src = 4'(src); gnt_data = d;
        gnt_corrupt = corr; gnt_denied = den; poison = pois; flush = with_flush;
        @(negedge clk);
        gnt_valid = 0; poison = 0; flush = 0; gnt_corrupt = 0; gnt_denied = 0;
        chk(resp_valid == exp_resp, tag, 64'(resp_valid), 64'(exp_resp));
        chk(meta_we == exp_we, tag, 64'(meta_we), 64'(exp_we));
        chk(data_we == exp_we, tag, 64'(data_we), 64'(exp_we));
        if (exp_resp) begin
            chk(resp_addr == exp_addr, tag, 64'(resp_addr), 64'(exp_addr));
            chk(resp_data == d, tag, resp_data[63:0], d[63:0]);
            chk(resp_corrupt == corr, tag, 64'(resp_corrupt), 64'(corr));
            chk(resp_denied == den, tag, 64'(resp_denied), 64'(den));
        end
        if (exp_we) begin
            chk(data_parity == dp, "R6 data parity", 64'(data_parity), 64'(dp));
            chk(meta_parity == ((^exp_addr) ^ pois), "R6 meta parity", 64'(meta_parity),
                64'((^exp_addr) ^ pois));
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(fetch_req_ready && pf_req_ready, "R1 readies", 64'({fetch_req_ready, pf_req_ready}), 64'd3);
        chk(!bus_req_valid, "R1 bus", 64'(bus_req_valid), 64'd0);
        chk(!resp_valid && !meta_we && !data_we, "R1 reply/we",
            64'({resp_valid, meta_we, data_we}), 64'd0);
    endtask

    task automatic t_order;
        req(0, '0, 1, 26'h100, 0, 1, "R2 pf alloc");
        req(1, 26'h200, 0, '0, 1, 0, "R2 fetch alloc");
        req(1, 26'h201, 0, '0, 1, 0, "R2 fetch alloc");
        issue(0, 26'h200, "R3 fetch first");
        issue(1, 26'h201, "R3 fetch second");
        issue(4, 26'h100, "R2 prefetch id");
        bus_idle("R2 single send");
        grant(0, 64'h11, 0, 1, 0, 0, 1, 1, 26'h200, "R5 grant denied");
        grant(1, 64'h22, 1, 0, 1, 0, 1, 1, 26'h201, "R6 grant poisoned");
        grant(4, 64'h33, 0, 0, 0, 0, 1, 1, 26'h100, "R5 grant prefetch");
        @(negedge clk);
        chk(!resp_valid, "R5 reply one cycle", 64'(resp_valid), 64'd0);
        req(1, 26'h300, 0, '0, 1, 0, "R2 reuse");
        issue(0, 26'h300, "R2 freed entry reused");
        grant(0, 64'h44, 0, 0, 0, 0, 1, 1, 26'h300, "R5 reuse grant");
    endtask

    task automatic t_merge;
        req(1, 26'h400, 0, '0, 1, 0, "R4 first");
        req(0, '0, 1, 26'h400, 0, 1, "R4 pf merge");
        req(1, 26'h400, 0, '0, 1, 0, "R4 fetch merge");
        req(1, 26'h500, 1, 26'h500, 1, 1, "R4 same cycle");
        issue(0, 26'h400, "R4 one request");
        issue(1, 26'h500, "R4 one request same cycle");
        bus_idle("R4 no duplicate");
        grant(0, 64'h55, 0, 0, 0, 0, 1, 1, 26'h400, "R4 grant");
        grant(1, 64'h66, 0, 0, 0, 0, 1, 1, 26'h500, "R4 grant");
    endtask

    task automatic t_full;
        for (int i = 0; i < 4; i++) req(1, 26'hA00 + 26'(i), 0, '0, 1, 0, "R11 fill");
        req(1, 26'hA10, 1, 26'hA20, 0, 1, "R11 full");
        req(1, 26'hA01, 0, '0, 1, 0, "R11 full merge");
        for (int i = 0; i < 4; i++) issue(i, 26'hA00 + 26'(i), "R11 drain");
        issue(4, 26'hA20, "R11 prefetch pool independent");
        for (int i = 0; i < 4; i++)
            grant(i, 64'(i + 7), 0, 0, 0, 0, 1, 1, 26'hA00 + 26'(i), "R11 retire");
        grant(4, 64'h77, 0, 0, 0, 0, 1, 1, 26'hA20, "R11 retire");
    endtask

    task automatic t_flush_unsent;
        req(1, 26'h600, 0, '0, 1, 0, "R7 alloc");
        @(negedge clk);
        #1;
        chk(bus_req_valid, "R7 pending", 64'(bus_req_valid), 64'd1);
        flush = 1;
        #1;
        chk(!fetch_req_ready && !pf_req_ready, "R10 ready low", 64'({fetch_req_ready, pf_req_ready}), 64'd0);
        chk(!bus_req_valid, "R10 no bus", 64'(bus_req_valid), 64'd0);
        @(negedge clk);
        flush = 0;
        #1;
        chk(!bus_req_valid, "R7 removed", 64'(bus_req_valid), 64'd0);
        chk(fetch_req_ready, "R10 ready back", 64'(fetch_req_ready), 64'd1);
        grant(0, 64'h88, 0, 0, 0, 0, 0, 0, '0, "R7 stale grant");
    endtask

    task automatic t_flush_sent;
        req(1, 26'h700, 0, '0, 1, 0, "R8 alloc");
        issue(0, 26'h700, "R8 send");
        @(negedge clk);
        fence = 1;
        #1;
        chk(!fetch_req_ready, "R10 fence ready", 64'(fetch_req_ready), 64'd0);
        @(negedge clk);
        fence = 0;
        req(1, 26'h700, 0, '0, 1, 0, "R8 no match");
        issue(1, 26'h700, "R8 entry held");
        grant(0, 64'h99, 0, 0, 0, 0, 0, 0, '0, "R8 dropped");
        req(1, 26'h800, 0, '0, 1, 0, "R8 freed");
        issue(0, 26'h800, "R8 freed reused");
        grant(1, 64'hAA, 0, 0, 0, 0, 1, 1, 26'h700, "R8 clean");
        grant(0, 64'hBB, 0, 0, 0, 0, 1, 1, 26'h800, "R8 clean");
    endtask

    task automatic t_gnt_flush;
        req(0, '0, 1, 26'h900, 0, 1, "R9 alloc");
        issue(4, 26'h900, "R9 send");
        grant(4, 64'hCC, 1, 0, 0, 1, 1, 0, 26'h900, "R9 grant with flush");
        bus_idle("R9 idle");
    endtask

    bit done = 0;
    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_order();
        t_merge();
        t_full();
        t_flush_unsent();
        t_flush_sent();
        t_gnt_flush();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule